// File: doc/BRIEF.md
# Level/Pulse Interrupt Pending Controller

This block gathers a small set of interrupt request lines and gives one interrupt request to a CPU. Each line is set up either as level-type, where the pending bit follows a high input, or as pulse-type, where a rising edge latches the pending bit. Software clears a pending bit by writing a one to it. A level line that is still high when its bit is cleared sets the bit again at once, so a request that fires again during its own handler is never lost.

Software works through a four-entry register window: line kinds, enable mask, pending bits, and a vector port. A read of the vector port picks the pending, enabled line with the lowest index and returns its number, which is the index plus one. That read also locks the choice, and the request output stays low until software writes the same number back to the vector port. When nothing is pending at read time, the port returns 0, and software acknowledges with 0.

Top module: `irq_pend_ctl`

## Requirements
- R1: After reset, the kind, mask and pending registers read 0 and `irq_o` is low. Written kind (address 0, 1 = pulse) and mask (address 1) values read back unchanged.
- R2: For a level line (kind bit 0), a high input sets its pending bit (address 2) at the next clock edge. Writing one to clear that bit while the input is still high leaves the bit set, and `irq_o` stays high.
- R3: Clearing a level line's pending bit while its input is low makes the bit read 0 from the next cycle.
- R4: For a pulse line (kind bit 1), a rising input edge sets the pending bit. An input held high sets nothing new after a clear. A later new edge sets the bit again.
- R5: A write to address 2 clears only the bits written as one. All other pending bits are kept.
- R6: Mask bit 0 keeps a line out of `irq_o`, but its pending bit is still captured and readable.
- R7: A read of address 3 returns the lowest-index pending enabled line as index+1.
- R8: After a vector read, `irq_o` stays low until the acknowledge. Further vector reads return the same latched number, even if another line becomes pending.
- R9: A write to address 3 with a number other than the latched one is ignored. A write with the latched number ends the service, and `irq_o` follows the pending state again from the next cycle.
- R10: A vector read with no pending enabled line returns 0 (spurious). The controller then waits for an acknowledge with 0.
- R11: When a pulse edge and a clear-by-one for the same line fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Raw interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 kind, 1 mask, 2 pending clear, 3 acknowledge |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Register read strobe (a read of address 3 locks the vector) |
| rd_addr | input | 2 | Read address: 0 kind, 1 mask, 2 pending, 3 vector |
| rd_data | output | DATA_W | Read data, combinational while rd_en is high |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
A stranded level line shows up as a pending bit that reads 0 the cycle after a clear while its input is still high. `irq_o` then drops in that same cycle. A wrong priority or a lost latch shows up in the number returned by the very next vector read. A leaking service state shows up as `irq_o` rising before the matching acknowledge, or staying low one cycle after it. Every one of these faults can be seen at the ports within one or two cycles of the stimulus that causes it.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

   typedef enum logic [1:0] {
      SEL_KIND = 2'd0,
      SEL_MASK = 2'd1,
      SEL_PEND = 2'd2,
      SEL_VEC  = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [NUM_SRC-1:0] kind_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pend_o
);

   logic [NUM_SRC-1:0] src_q;

   always_ff @(posedge clk) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src_i;
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
      logic set_w;
      logic pend_q;

      if (1) begin : g_sel
         always_comb begin
            if (kind_i[i]) set_w = src_i[i] & ~src_q[i];
            else           set_w = src_i[i];
         end
      end

      // a set beats a clear in the same cycle
      always_ff @(posedge clk) begin
         if (!rst_n) pend_q <= 1'b0;
         else        pend_q <= (pend_q & ~clr_i[i]) | set_w;
      end

      assign pend_o[i] = pend_q;

      // R2
      lvl_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!kind_i[i] && src_i[i]) |=> pend_o[i]);

      // R3
      lvl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!kind_i[i] && !src_i[i] && clr_i[i]) |=> !pend_o[i]);

      // R4, R11
      pls_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (kind_i[i] && $rose(src_i[i])) |=> pend_o[i]);
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int NUM_SRC = 8,
   parameter int ID_W    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   output logic               hit_o,
   output logic [ID_W-1:0]    num_o
);

   always_comb begin
      num_o = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req_i[i]) num_o = ID_W'(i + 1);
      end
   end

   assign hit_o = |req_i;

   // R7
   lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[0] |-> (num_o == ID_W'(1)));

   // R7
   pick_is_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> req_i[int'(num_o) - 1]);

   // R10
   none_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i == '0) |-> (num_o == '0));

endmodule

// File: rtl/irq_vec_hold.sv
module irq_vec_hold #(
   parameter int ID_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            vec_rd_i,
   input  logic            ack_wr_i,
   input  logic [ID_W-1:0] ack_num_i,
   input  logic [ID_W-1:0] cand_num_i,
   output logic            busy_o,
   output logic [ID_W-1:0] num_o
);

   logic            busy_q;
   logic [ID_W-1:0] lat_q;
   logic            ack_hit;

   assign ack_hit = busy_q & ack_wr_i & (ack_num_i == lat_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         lat_q  <= '0;
      end else if (!busy_q) begin
         if (vec_rd_i) begin
            busy_q <= 1'b1;
            lat_q  <= cand_num_i;
         end
      end else if (ack_hit) begin
         busy_q <= 1'b0;
      end
   end

   assign busy_o = busy_q;
   assign num_o  = busy_q ? lat_q : cand_num_i;

   // R8, R9
   hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !(ack_wr_i && ack_num_i == num_o)) |=> (busy_o && $stable(num_o)));

   // R9
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && ack_wr_i && ack_num_i == num_o) |=> !busy_o);

endmodule

// File: rtl/irq_pend_ctl.sv
module irq_pend_ctl
   import irq_pend_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               rd_en,
   input  logic [1:0]         rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   output logic               irq_o
);

   localparam int ID_W = $clog2(NUM_SRC + 1);

   if (NUM_SRC < 1) begin : g_bad_num
      $error("irq_pend_ctl: NUM_SRC must be at least 1");
   end
   if (DATA_W < NUM_SRC) begin : g_bad_width
      $error("irq_pend_ctl: DATA_W must hold one bit per source");
   end
   if (DATA_W < ID_W) begin : g_bad_id
      $error("irq_pend_ctl: DATA_W must hold a source number");
   end

   logic [NUM_SRC-1:0] kind_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] clr_w;
   logic [NUM_SRC-1:0] pend_w;
   logic [NUM_SRC-1:0] live_w;
   logic               hit_w;
   logic [ID_W-1:0]    cand_w;
   logic [ID_W-1:0]    vec_w;
   logic               busy_w;
   logic               vec_rd_w;
   logic               ack_wr_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= '0;
         mask_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == SEL_KIND) kind_q <= wr_data[NUM_SRC-1:0];
         if (wr_addr == SEL_MASK) mask_q <= wr_data[NUM_SRC-1:0];
      end
   end

   assign clr_w    = (wr_en && wr_addr == SEL_PEND) ? wr_data[NUM_SRC-1:0] : '0;
   assign vec_rd_w = rd_en && rd_addr == SEL_VEC;
   assign ack_wr_w = wr_en && wr_addr == SEL_VEC;

   irq_src_capture #(.NUM_SRC(NUM_SRC)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i),
      .kind_i (kind_q),
      .clr_i  (clr_w),
      .pend_o (pend_w)
   );

   assign live_w = pend_w & mask_q;

   irq_prio_pick #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (live_w),
      .hit_o (hit_w),
      .num_o (cand_w)
   );

   irq_vec_hold #(.ID_W(ID_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .vec_rd_i   (vec_rd_w),
      .ack_wr_i   (ack_wr_w),
      .ack_num_i  (wr_data[ID_W-1:0]),
      .cand_num_i (cand_w),
      .busy_o     (busy_w),
      .num_o      (vec_w)
   );

   assign irq_o = hit_w & ~busy_w;

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         unique case (rd_addr)
            SEL_KIND: rd_data[NUM_SRC-1:0] = kind_q;
            SEL_MASK: rd_data[NUM_SRC-1:0] = mask_q;
            SEL_PEND: rd_data[NUM_SRC-1:0] = pend_w;
            SEL_VEC:  rd_data[ID_W-1:0]    = vec_w;
            default:  rd_data = '0;
         endcase
      end
   end

   // R8
   irq_quiet_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_w |-> !irq_o);

   // R6
   mask_gates_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq_o);

   // R8
   vec_read_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_rd_w |=> busy_w);

endmodule

// File: tb/irq_pend_ctl_test.sv
module irq_pend_ctl_test;

   localparam int NUM_SRC = 8;
   localparam int DATA_W  = 32;
   localparam int NROWS   = 54;

   typedef struct packed {
      logic [7:0] src;
      logic       wr;
      logic       rd;
      logic [1:0] addr;
      logic [7:0] wdat;
      logic [7:0] exp_rd;
      logic       exp_irq;
      logic [3:0] req;
   } row_t;

   // fields: src, wr, rd, addr, wdat, exp_rd, exp_irq, requirement
   // exp_* describe the state before this row's clock edge
   localparam row_t ROWS [NROWS] = '{
      {8'h00,1'b1,1'b0,2'd1,8'hFF,8'h00,1'b0,4'd1},   // R1 mask all on
      {8'h04,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,4'd2},   // R2 level high
      {8'h04,1'b0,1'b1,2'd2,8'h00,8'h04,1'b1,4'd2},
      {8'h04,1'b1,1'b0,2'd2,8'h04,8'h00,1'b1,4'd2},   // R2 clear while high
      {8'h04,1'b0,1'b1,2'd2,8'h00,8'h04,1'b1,4'd2},   // R2 re-armed
      {8'h00,1'b1,1'b0,2'd2,8'h04,8'h00,1'b1,4'd3},
      {8'h00,1'b0,1'b1,2'd2,8'h00,8'h00,1'b0,4'd3},   // R3
      {8'h0A,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,4'd5},
      {8'h00,1'b0,1'b1,2'd2,8'h00,8'h0A,1'b1,4'd5},
      {8'h00,1'b1,1'b0,2'd2,8'h02,8'h00,1'b1,4'd5},
      {8'h00,1'b0,1'b1,2'd2,8'h00,8'h08,1'b1,4'd5},   // R5 bit3 kept
      {8'h00,1'b1,1'b0,2'd2,8'h08,8'h00,1'b1,4'd5},
      {8'h00,1'b0,1'b1,2'd2,8'h00,8'h00,1'b0,4'd5},
      {8'h00,1'b1,1'b0,2'd0,8'h10,8'h00,1'b0,4'd4},   // R4 line 4 pulse
      {8'h10,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,4'd4},
      {8'h10,1'b0,1'b1,2'd2,8'h00,8'h10,1'b1,4'd4},
      {8'h10,1'b1,1'b0,2'd2,8'h10,8'h00,1'b1,4'd4},
      {8'h10,1'b0,1'b1,2'd2,8'h00,8'h00,1'b0,4'd4},   // R4 held, no re-set
      {8'h00,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,4'd4},
      {8'h10,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,4'd4},
      {8'h10,1'b0,1'b1,2'd2,8'h00,8'h10,1'b1,4'd4},   // R4 new edge
      {8'h00,1'b1,1'b0,2'd2,8'h10,8'h00,1'b1,4'd4},
      {8'h00,1'b0,1'b1,2'd2,8'h00,8'h00,1'b0,4'd4},
      {8'h10,1'b1,1'b0,2'd2,8'h10,8'h00,1'b0,4'd11},  // R11 edge + clear
      {8'h10,1'b0,1'b1,2'd2,8'h00,8'h10,1'b1,4'd11},
      {8'h00,1'b1,1'b0,2'd2,8'h10,8'h00,1'b1,4'd11},
      {8'h00,1'b0,1'b1,2'd2,8'h00,8'h00,1'b0,4'd11},
      {8'h00,1'b1,1'b0,2'd1,8'h01,8'h00,1'b0,4'd6},   // R6 mask line 0 only
      {8'h04,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,4'd6},
      {8'h04,1'b0,1'b1,2'd2,8'h00,8'h04,1'b0,4'd6},
      {8'h00,1'b1,1'b0,2'd2,8'h04,8'h00,1'b0,4'd6},
      {8'h00,1'b1,1'b0,2'd1,8'hFF,8'h00,1'b0,4'd6},
      {8'h24,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,4'd7},
      {8'h24,1'b0,1'b1,2'd3,8'h00,8'h03,1'b1,4'd7},   // R7 line 2 -> 3
      {8'h25,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,4'd8},
      {8'h25,1'b0,1'b1,2'd3,8'h00,8'h03,1'b0,4'd8},   // R8 held number
      {8'h25,1'b1,1'b0,2'd3,8'h01,8'h00,1'b0,4'd9},   // R9 wrong ack
      {8'h25,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,4'd9},
      {8'h21,1'b1,1'b0,2'd2,8'h04,8'h00,1'b0,4'd9},
      {8'h21,1'b1,1'b0,2'd3,8'h03,8'h00,1'b0,4'd9},   // R9 right ack
      {8'h21,1'b0,1'b1,2'd3,8'h00,8'h01,1'b1,4'd7},   // R7 line 0 wins
      {8'h20,1'b1,1'b0,2'd2,8'h01,8'h00,1'b0,4'd8},
      {8'h20,1'b1,1'b0,2'd3,8'h01,8'h00,1'b0,4'd9},
      {8'h20,1'b0,1'b1,2'd3,8'h00,8'h06,1'b1,4'd7},
      {8'h00,1'b1,1'b0,2'd2,8'h20,8'h00,1'b0,4'd8},
      {8'h00,1'b1,1'b0,2'd3,8'h06,8'h00,1'b0,4'd9},
      {8'h00,1'b0,1'b1,2'd2,8'h00,8'h00,1'b0,4'd3},
      {8'h00,1'b0,1'b1,2'd3,8'h00,8'h00,1'b0,4'd10},  // R10 spurious
      {8'h02,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,4'd10},
      {8'h02,1'b0,1'b1,2'd2,8'h00,8'h02,1'b0,4'd10},
      {8'h02,1'b1,1'b0,2'd3,8'h00,8'h00,1'b0,4'd10},  // R10 ack 0
      {8'h02,1'b0,1'b0,2'd0,8'h00,8'h00,1'b1,4'd10},
      {8'h00,1'b1,1'b0,2'd2,8'h02,8'h00,1'b1,4'd10},
      {8'h00,1'b0,1'b1,2'd2,8'h00,8'h00,1'b0,4'd10}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NUM_SRC-1:0] src_i = '0;
   logic               wr_en = 1'b0;
   logic [1:0]         wr_addr = '0;
   logic [DATA_W-1:0]  wr_data = '0;
   logic               rd_en = 1'b0;
   logic [1:0]         rd_addr = '0;
   logic [DATA_W-1:0]  rd_data;
   logic               irq_o;

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;

   always #2 clk = ~clk;

   irq_pend_ctl #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_i   (src_i),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .irq_o   (irq_o)
   );

   task automatic chk_val(input string tag, input logic [DATA_W-1:0] act,
                          input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic apply(input row_t r);
      @(negedge clk);
      src_i   = r.src;
      wr_en   = r.wr;
      wr_addr = r.addr;
      wr_data = DATA_W'(r.wdat);
      rd_en   = r.rd;
      rd_addr = r.addr;
      #1;
      chk_val($sformatf("R%0d irq", r.req), DATA_W'(irq_o), DATA_W'(r.exp_irq));
      if (r.rd)
         chk_val($sformatf("R%0d read addr %0d", r.req, r.addr), rd_data, DATA_W'(r.exp_rd));
   endtask

   task automatic idle_read(input logic [1:0] a, output logic [DATA_W-1:0] v);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b1; rd_addr = a;
      #1 v = rd_data;
   endtask

   initial begin
      logic [DATA_W-1:0] v;
      repeat (3) @(posedge clk);
      // R1 reset state
      @(negedge clk) rst_n = 1'b1;
      idle_read(2'd0, v); chk_val("R1 kind after reset", v, '0);
      idle_read(2'd1, v); chk_val("R1 mask after reset", v, '0);
      idle_read(2'd2, v); chk_val("R1 pending after reset", v, '0);
      chk_val("R1 irq after reset", DATA_W'(irq_o), '0);
      @(negedge clk) rd_en = 1'b0;

      for (int i = 0; i < NROWS; i++) apply(ROWS[i]);

      // R1 readback of configuration
      idle_read(2'd0, v); chk_val("R1 kind readback", v, 32'h10);
      idle_read(2'd1, v); chk_val("R1 mask readback", v, 32'hFF);

      // R2 re-trigger during handler: input back high before the clear
      @(negedge clk) rd_en = 1'b0; src_i = 8'h08;
      @(negedge clk) src_i = 8'h00;
      @(negedge clk) src_i = 8'h08;
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h08;
      @(negedge clk) wr_en = 1'b0;
      #1 chk_val("R2 irq after clear with input high", DATA_W'(irq_o), 32'h1);
      idle_read(2'd2, v); chk_val("R2 pending after re-trigger", v, 32'h08);

      // R1 reset in the middle of activity
      @(negedge clk) rd_en = 1'b0; src_i = 8'h00; rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      idle_read(2'd2, v); chk_val("R1 pending after second reset", v, '0);
      idle_read(2'd0, v); chk_val("R1 kind after second reset", v, '0);
      chk_val("R1 irq after second reset", DATA_W'(irq_o), '0);
      @(negedge clk) rd_en = 1'b0;

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule